// File: doc/BRIEF.md
# 64-bit Tick Timer with Compare Alarms

This block holds a 64-bit up-counter that starts at zero when reset is released and advances by one on each clock cycle in which the tick-enable input is high. A parameterised number of alarm slots (four by default) each compare a 32-bit target against the low word of the count. When an alarm fires it sets its own interrupt line.

Software reaches the block through a plain word-wide port. Writes complete in a single cycle. Read data appears on the cycle after the read strobe. The 64-bit count is written as two halves, and the upper half is committed together with the lower half. It is also read as two halves, and reading the low word snapshots the high word, so a carry between the two reads cannot tear the value. Each alarm has an enable bit and a running flag, and software clears an alarm interrupt by writing 1 to its bit. A sticky lock bit freezes the time and the alarm configuration until the next reset.

Register word addresses (4-bit `addr_i`): 0 stage low time word, 1 commit high time word, 2 read low time word, 3 read snapped high word, 4+n alarm n target, 8 alarm enables, 9 running flags (read-only), 10 interrupt flags, 11 lock.

Top module: `tick_timer64`

## Requirements
- R1: After reset the count is 0. It increments by exactly 1 on each clock edge where `tick_i` is high and holds otherwise. It keeps counting while the lock is set.
- R2: A read strobe at address 2 returns the current count bits [31:0] on `rdata_o` one cycle later. A read at address 3 returns the high word that was captured by the most recent address-2 read.
- R3: A write to address 0 only stages a low word and leaves the count unchanged. A write to address 1 loads the count with {written data, staged low word} in one step.
- R4: The high word returned at address 3 does not change when the counter carries between an address-2 read and the following address-3 read.
- R5: Address 8 bits [N-1:0] are the read/write alarm enables. Writing alarm n's target at address 4+n sets it running only if enable bit n is set. Otherwise the target is only stored. Targets read back at the same address.
- R6: Address 9 bits [N-1:0] read the running flag of each alarm.
- R7: Writing 0 to an alarm's enable bit clears its running flag, and that alarm then does not fire.
- R8: A running alarm whose target equals count bits [31:0] sets its interrupt flag and clears its running flag on the next clock edge. This includes a target equal to the count at the moment of arming.
- R9: `irq_o` mirrors the interrupt flags, which read at address 10. Writing 1 to bit n at address 10 clears flag n. Writing 0 leaves it unchanged.
- R10: Writing 1 to bit 0 of address 11 sets a lock that only reset clears. While it is set, writes to addresses 0, 1, 4..7 and 8 have no effect.
- R11: The lock reads back as bit 0 of address 11. Interrupt clears at address 10 still work while the lock is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable for the current cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | N_ALARM | Per-alarm interrupt flags |

## Verification
The bench loads a count just below a 32-bit carry and reads it back across the carry. A design that re-sampled the high word on the high read would return a value one too large. It then checks that a lone low-word write leaves the count alone, which catches a load committed on the wrong half. Alarms are armed with enable both set and clear, cancelled before their target, and armed at a target equal to the current count. A wrong compare or a missing enable qualifier shows up as a spurious, missing or late interrupt bit. Finally it locks the block and tries every protected write. It also confirms that interrupt clearing and counting carry on under the lock and that only reset drops the lock.

// File: rtl/tick_timer64_pkg.sv
package tick_timer64_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;
  localparam int unsigned MAX_ALARMS = 4;

  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_SET_LO = 4'd0;
  localparam addr_t A_SET_HI = 4'd1;
  localparam addr_t A_GET_LO = 4'd2;
  localparam addr_t A_GET_HI = 4'd3;
  localparam addr_t A_TGT0   = 4'd4;
  localparam addr_t A_ENA    = 4'd8;
  localparam addr_t A_RUN    = 4'd9;
  localparam addr_t A_IRQ    = 4'd10;
  localparam addr_t A_LOCK   = 4'd11;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tt_alarm.sv
module tt_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] now_i,
  input  logic         en_wr_i,
  input  logic         en_val_i,
  input  logic         tgt_wr_i,
  input  logic [W-1:0] tgt_val_i,
  input  logic         irq_clr_i,
  output logic         en_o,
  output logic         run_o,
  output logic [W-1:0] tgt_o,
  output logic         irq_o
);
  logic         en_q, run_q, irq_q;
  logic [W-1:0] tgt_q;
  logic         en_nxt, hit;

  assign en_nxt = en_wr_i ? en_val_i : en_q;
  assign hit    = run_q && (now_i == tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (tgt_wr_i) tgt_q <= tgt_val_i;
      // cancel beats re-arm beats fire
      if (!en_nxt)       run_q <= 1'b0;
      else if (tgt_wr_i) run_q <= 1'b1;
      else if (hit)      run_q <= 1'b0;
      // a fresh hit wins over a clear in the same cycle
      if (hit)            irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign en_o  = en_q;
  assign run_o = run_q;
  assign tgt_o = tgt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tick_timer64_pkg::*;
#(
  parameter int unsigned N_ALARM = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [N_ALARM-1:0] irq_o
);
  localparam int unsigned TW = 2 * DW;

  logic          lock_q;
  logic          wr_ok;
  logic          time_ld;
  logic [DW-1:0] stage_q, hi_snap_q, rdata_q, rd_val;
  logic [TW-1:0] now;

  logic [N_ALARM-1:0] en_v, run_v, irq_v;
  logic [DW-1:0]      tgt_v [N_ALARM];

  assign wr_ok   = wr_en_i && !lock_q;
  assign time_ld = wr_ok && (addr_i == A_SET_HI);

  tt_counter #(.W(TW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (time_ld),
    .load_val_i ({wdata_i, stage_q}),
    .cnt_o      (now)
  );

  for (genvar g = 0; g < N_ALARM; g++) begin : g_alm
    tt_alarm #(.W(DW)) u_alm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .now_i     (now[DW-1:0]),
      .en_wr_i   (wr_ok && (addr_i == A_ENA)),
      .en_val_i  (wdata_i[g]),
      .tgt_wr_i  (wr_ok && (addr_i == A_TGT0 + addr_t'(g))),
      .tgt_val_i (wdata_i),
      .irq_clr_i (wr_en_i && (addr_i == A_IRQ) && wdata_i[g]),
      .en_o      (en_v[g]),
      .run_o     (run_v[g]),
      .tgt_o     (tgt_v[g]),
      .irq_o     (irq_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_ok && (addr_i == A_SET_LO)) stage_q <= wdata_i;
      if (wr_en_i && (addr_i == A_LOCK) && wdata_i[0]) lock_q <= 1'b1;
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (addr_i)
      A_GET_LO: rd_val = now[DW-1:0];
      A_GET_HI: rd_val = hi_snap_q;
      A_ENA:    rd_val = DW'(en_v);
      A_RUN:    rd_val = DW'(run_v);
      A_IRQ:    rd_val = DW'(irq_v);
      A_LOCK:   rd_val = DW'(lock_q);
      default:  rd_val = '0;
    endcase
    for (int i = 0; i < N_ALARM; i++)
      if (addr_i == A_TGT0 + addr_t'(i)) rd_val = tgt_v[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q   <= '0;
      hi_snap_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rd_val;
      if (addr_i == A_GET_LO) hi_snap_q <= now[TW-1:DW];
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_v;
endmodule

// File: rtl/tick_timer64_chk.sv
module tick_timer64_chk #(
  parameter int unsigned N_ALARM = 4,
  parameter int unsigned TW = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               wr_en_i,
  input logic [3:0]         addr_i,
  input logic               lock_q,
  input logic [TW-1:0]      now,
  input logic [N_ALARM-1:0] en_v,
  input logic [N_ALARM-1:0] run_v,
  input logic [N_ALARM-1:0] irq_o
);
  a_r1_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(wr_en_i && !lock_q && addr_i == 4'd1)) |=> (now == $past(now) + TW'(1)));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(wr_en_i && !lock_q && addr_i == 4'd1)) |=> $stable(now));

  a_r10_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  a_r10_locked_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !tick_i) |=> $stable(now));

  for (genvar g = 0; g < N_ALARM; g++) begin : g_chk
    a_r7_run_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_v[g] |-> en_v[g]);

    a_r8_irq_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> $past(run_v[g]));

    a_r8_fire_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(irq_o[g]) && !$past(wr_en_i)) |-> !run_v[g]);

    a_r10_locked_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(lock_q) |-> $stable(en_v[g]));
  end
endmodule

bind tick_timer64 tick_timer64_chk #(.N_ALARM(N_ALARM), .TW(TW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .lock_q  (lock_q),
  .now     (now),
  .en_v    (en_v),
  .run_v   (run_v),
  .irq_o   (irq_o)
);

// File: tb/tick_timer64_tb_top.sv
`timescale 1ns/1ps
module tick_timer64_tb_top;
  localparam int unsigned NA = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [3:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NA-1:0] irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timer64 #(.N_ALARM(NA)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // op: 0 write, 1 read and compare, 2 tick n cycles then 2 idle, 3 compare irq_o after one cycle
  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 4'd0,  32'hFFFF_FFFE, 4'd3},  // R3 stage low
    '{2'd0, 4'd1,  32'h0000_0007, 4'd3},  // R3 commit
    '{2'd1, 4'd2,  32'hFFFF_FFFE, 4'd2},  // R2
    '{2'd1, 4'd3,  32'h0000_0007, 4'd3},  // R3
    '{2'd2, 4'd0,  32'd3,         4'd1},
    '{2'd1, 4'd2,  32'h0000_0001, 4'd1},  // R1 three ticks
    '{2'd1, 4'd3,  32'h0000_0008, 4'd1},  // R1 carry into high
    '{2'd0, 4'd0,  32'hFFFF_FFFF, 4'd3},
    '{2'd0, 4'd1,  32'h0000_0001, 4'd3},
    '{2'd1, 4'd2,  32'hFFFF_FFFF, 4'd4},
    '{2'd2, 4'd0,  32'd1,         4'd4},
    '{2'd1, 4'd3,  32'h0000_0001, 4'd4},  // R4 snapshot survives carry
    '{2'd1, 4'd2,  32'h0000_0000, 4'd4},
    '{2'd1, 4'd3,  32'h0000_0002, 4'd4},
    '{2'd0, 4'd0,  32'h0000_1234, 4'd3},  // R3 stage alone
    '{2'd1, 4'd2,  32'h0000_0000, 4'd3},  // R3 count unchanged
    '{2'd0, 4'd0,  32'h0000_0000, 4'd3},
    '{2'd0, 4'd1,  32'h0000_0000, 4'd3},
    '{2'd0, 4'd8,  32'h0000_0003, 4'd5},
    '{2'd1, 4'd8,  32'h0000_0003, 4'd5},  // R5 enables read back
    '{2'd0, 4'd4,  32'd5,         4'd5},
    '{2'd0, 4'd5,  32'd3,         4'd5},
    '{2'd0, 4'd6,  32'd2,         4'd5},  // enable 2 clear: stored only
    '{2'd1, 4'd9,  32'h0000_0003, 4'd6},  // R6
    '{2'd1, 4'd6,  32'd2,         4'd5},  // R5 target read back
    '{2'd2, 4'd0,  32'd3,         4'd8},
    '{2'd1, 4'd9,  32'h0000_0001, 4'd8},  // R8 alarm1 stopped
    '{2'd3, 4'd0,  32'h0000_0002, 4'd8},  // R8 only alarm1 fired
    '{2'd2, 4'd0,  32'd2,         4'd8},
    '{2'd3, 4'd0,  32'h0000_0003, 4'd8},
    '{2'd1, 4'd10, 32'h0000_0003, 4'd9},  // R9
    '{2'd0, 4'd10, 32'h0000_0001, 4'd9},
    '{2'd3, 4'd0,  32'h0000_0002, 4'd9},  // R9 W1C
    '{2'd0, 4'd10, 32'h0000_0000, 4'd9},
    '{2'd3, 4'd0,  32'h0000_0002, 4'd9},  // R9 zero no effect
    '{2'd0, 4'd4,  32'd9,         4'd7},
    '{2'd1, 4'd9,  32'h0000_0001, 4'd7},
    '{2'd0, 4'd8,  32'h0000_0002, 4'd7},  // R7 cancel alarm0
    '{2'd1, 4'd9,  32'h0000_0000, 4'd7},
    '{2'd2, 4'd0,  32'd5,         4'd7},
    '{2'd3, 4'd0,  32'h0000_0002, 4'd7},  // R7 no fire at 9
    '{2'd0, 4'd8,  32'h0000_0003, 4'd8},
    '{2'd0, 4'd4,  32'd10,        4'd8},
    '{2'd3, 4'd0,  32'h0000_0003, 4'd8},  // R8 target equals count
    '{2'd0, 4'd10, 32'h0000_0001, 4'd9},
    '{2'd3, 4'd0,  32'h0000_0002, 4'd9},
    '{2'd0, 4'd11, 32'h0000_0001, 4'd10}, // R10 lock
    '{2'd0, 4'd0,  32'h0000_0123, 4'd10},
    '{2'd0, 4'd1,  32'h0000_0456, 4'd10},
    '{2'd1, 4'd2,  32'd10,        4'd10}, // R10 time held
    '{2'd1, 4'd3,  32'h0000_0000, 4'd10},
    '{2'd0, 4'd8,  32'h0000_0000, 4'd10},
    '{2'd1, 4'd8,  32'h0000_0003, 4'd10}, // R10 enables held
    '{2'd0, 4'd5,  32'd10,        4'd10},
    '{2'd1, 4'd9,  32'h0000_0000, 4'd10},
    '{2'd1, 4'd5,  32'd3,         4'd10}, // R10 target held
    '{2'd0, 4'd11, 32'h0000_0000, 4'd11},
    '{2'd1, 4'd11, 32'h0000_0001, 4'd11}, // R11 lock reads back
    '{2'd0, 4'd10, 32'h0000_0002, 4'd11},
    '{2'd3, 4'd0,  32'h0000_0000, 4'd11}, // R11 clear under lock
    '{2'd2, 4'd0,  32'd1,         4'd1},
    '{2'd1, 4'd2,  32'd11,        4'd1}   // R1 counts under lock
  };

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk); tick_i = 1'b1;
    for (int k = 0; k < n; k++) @(negedge clk);
    tick_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    chk(1, rdata_o, 32'h0);                 // R1 reset state
    chk(9, 32'(irq_o), 32'h0);              // R9 reset state
    rst_ni = 1'b1;
    do_rd(4'd2, rv); chk(1, rv, 32'h0);     // R1 count frozen without tick
    for (int i = 0; i < NV; i++) begin
      unique case (TBL[i].op)
        2'd0: do_wr(TBL[i].addr, TBL[i].data);
        2'd1: begin do_rd(TBL[i].addr, rv); chk(int'(TBL[i].req), rv, TBL[i].data); end
        2'd2: do_tick(int'(TBL[i].data));
        default: begin @(negedge clk); chk(int'(TBL[i].req), 32'(irq_o), TBL[i].data); end
      endcase
    end
    // R10 lock cleared only by reset
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(9, 32'(irq_o), 32'h0);
    rst_ni = 1'b1;
    do_rd(4'd11, rv); chk(10, rv, 32'h0);
    do_rd(4'd8, rv);  chk(5, rv, 32'h0);
    do_rd(4'd2, rv);  chk(1, rv, 32'h0);
    do_wr(4'd0, 32'h0000_00AA);
    do_wr(4'd1, 32'h0000_0001);
    do_rd(4'd2, rv);  chk(10, rv, 32'h0000_00AA); // writes accepted again
    do_rd(4'd3, rv);  chk(10, rv, 32'h0000_0001);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule